// File: doc/BRIEF.md
# Windowed RGB Histogram Generator

This block gathers per-frame statistics from a pixel stream. Each pixel is a 32-bit word that carries three 8-bit colour components. The block may also be used on YUV or HSV streams, where the same three lanes carry the equivalent components. A rectangular window selects the pixels that count. Inside the window, independent horizontal and vertical skip ratios thin the sample grid. For every channel the block keeps a minimum, a maximum and a running sum, and it keeps a bin histogram.

The bin storage has three layouts. The default layout holds three 64-bin histograms, one per component. The max-of-components layout holds a single 64-bin histogram of the largest component of each pixel. The fine layout holds one 256-bin histogram. Software programs the block and reads results through a word-addressed register port whose read data is combinational. Start-of-frame and end-of-frame pulses bound the counting, so the results stay frozen between frames while software reads them.

Register map (word addresses):

| Address | Purpose |
|---|---|
| 0x00 | Control: bit 0 clears the statistics now; bit 1 arms the clear at each start of frame |
| 0x01 | Window origin: left in bits [15:0], top in bits [31:16] |
| 0x02 | Window extent: width in bits [15:0], height in bits [31:16] |
| 0x03 | Mode: bit 0 selects fine mode, bit 1 selects max mode, horizontal skip ratio from bit 8, vertical skip ratio from bit 16 |
| 0x04 | Bin index for indirect reads |
| 0x05 | Count of the bin at that index |
| 0x08–0x0A | Packed extremes of slots 0–2: minimum in bits [7:0], maximum in bits [15:8] |
| 0x0C–0x0E | Sums of slots 0–2 |
| 0x40–0xFF | Direct read of bin storage entry (address − 0x40) |

Top module: `hist_gen`

## Requirements
- R1: After reset, the mode register reads 0, and the block is in 64-bin mode with max mode off. Every sum and every bin reads 0. Every packed extreme reads 0x00FF, which is minimum 255 and maximum 0.
- R2: A pixel counts only when pixValid is high, a frame is open, and its position lies in the window: left ≤ x < left+width and top ≤ y < top+height. The position counters x and y reset at start of frame. x advances on each valid pixel and returns to 0 after a pixel with pixEol high. y advances after each pixel with pixEol high.
- R3: With horizontal ratio h and vertical ratio v, a window pixel counts only when (x−left) is a multiple of h+1 and (y−top) is a multiple of v+1.
- R4: In the default mode, slot 0 is pixData[23:16], slot 1 is pixData[15:8] and slot 2 is pixData[7:0]. Bits [31:24] are ignored. Each slot's value increments bin entry slot*64 + (value>>2).
- R5: In max mode, slot 1 takes the largest of the three components. Only entries 64 + (max>>2) increment, and entries 0–63 and 128–191 stay 0.
- R6: In fine mode, the slot 1 value (the max when max mode is also set) increments entry equal to that value. The count is read by writing the index to 0x04 and then reading 0x05.
- R7: For each slot, the packed extremes hold the minimum and maximum of the counted values. The sum holds their total. The sum is CNTW+8 bits wide and saturates at all ones.
- R8: Bin counters saturate at 2^CNTW−1 and never wrap.
- R9: Writing 1 to control bit 0 returns all statistics to the reset values of R1 on the next cycle.
- R10: When control bit 1 is set, start of frame clears the statistics. When bit 1 is clear, statistics accumulate across frames.
- R11: After end of frame and until the next start of frame, pixels change no statistic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; no pixel is taken in this cycle |
| eof | input | 1 | End-of-frame pulse; no pixel is taken in this cycle |
| pixValid | input | 1 | Pixel present on pixData |
| pixEol | input | 1 | Current pixel is the last pixel of its line |
| pixData | input | 32 | Pixel, three 8-bit components in the low 24 bits |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr, combinational |

## Verification
The hardest states to reach are bin and sum saturation, because at the default counter width they need millions of pixels. The bench therefore builds the block with a 5-bit counter and feeds a frame in which every pixel has the same value, so bins pass their limit within one frame. The skip phases and window edges are exercised by frames with offsets and ratios that leave partial grids. The expected grid comes from modulo arithmetic rather than from phase counters. Freezing is reached by streaming a whole extra frame after end of frame without a new start pulse.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int COMPW = 8;

  typedef struct packed {
    logic             clear;
    logic             take;
    logic             fine;
    logic             maxRgb;
    logic [COMPW-1:0] histAddr;
  } ctlBus_t;
endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int COORDW = 13,
  parameter int RATIOW = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sof,
  input  logic        eof,
  input  logic        pixValid,
  input  logic        pixEol,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] cfgRdata,
  output ctlBus_t     ctl
);
  logic [COORDW-1:0] offX, offY, sizeW, sizeH, posX, posY;
  logic [RATIOW-1:0] hRatio, vRatio, hPh, vPh;
  logic              fine, maxRgb, autoClear, active;
  logic [COMPW-1:0]  histAddr;
  logic [COORDW:0]   xEnd, yEnd;
  logic              inH, inV;

  assign xEnd = {1'b0, offX} + {1'b0, sizeW};
  assign yEnd = {1'b0, offY} + {1'b0, sizeH};
  assign inH  = ({1'b0, posX} >= {1'b0, offX}) && ({1'b0, posX} < xEnd);
  assign inV  = ({1'b0, posY} >= {1'b0, offY}) && ({1'b0, posY} < yEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offX <= '0; offY <= '0; sizeW <= '0; sizeH <= '0;
      hRatio <= '0; vRatio <= '0; fine <= 1'b0; maxRgb <= 1'b0;
      autoClear <= 1'b0; histAddr <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        8'h00: autoClear <= regWdata[1];
        8'h01: begin offX <= regWdata[COORDW-1:0]; offY <= regWdata[16 +: COORDW]; end
        8'h02: begin sizeW <= regWdata[COORDW-1:0]; sizeH <= regWdata[16 +: COORDW]; end
        8'h03: begin
          fine <= regWdata[0]; maxRgb <= regWdata[1];
          hRatio <= regWdata[8 +: RATIOW]; vRatio <= regWdata[16 +: RATIOW];
        end
        8'h04: histAddr <= regWdata[COMPW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; posX <= '0; posY <= '0; hPh <= '0; vPh <= '0;
    end else begin
      if (sof) active <= 1'b1;
      else if (eof) active <= 1'b0;
      if (sof) begin
        posX <= '0; posY <= '0; hPh <= '0; vPh <= '0;
      end else if (pixValid) begin
        if (pixEol) begin
          posX <= '0;
          posY <= posY + 1'b1;
          hPh  <= '0;
          if (inV) vPh <= (vPh == vRatio) ? '0 : vPh + 1'b1;
        end else begin
          posX <= posX + 1'b1;
          if (inH) hPh <= (hPh == hRatio) ? '0 : hPh + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.clear    = (regWrEn && regAddr == 8'h00 && regWdata[0]) || (sof && autoClear);
    ctl.take     = pixValid && active && !sof && !eof && inH && inV &&
                   (hPh == '0) && (vPh == '0);
    ctl.fine     = fine;
    ctl.maxRgb   = maxRgb;
    ctl.histAddr = histAddr;
  end

  always_comb begin
    cfgRdata = '0;
    case (regAddr)
      8'h00: cfgRdata[1] = autoClear;
      8'h01: begin cfgRdata[COORDW-1:0] = offX; cfgRdata[16 +: COORDW] = offY; end
      8'h02: begin cfgRdata[COORDW-1:0] = sizeW; cfgRdata[16 +: COORDW] = sizeH; end
      8'h03: begin
        cfgRdata[0] = fine; cfgRdata[1] = maxRgb;
        cfgRdata[8 +: RATIOW] = hRatio; cfgRdata[16 +: RATIOW] = vRatio;
      end
      8'h04: cfgRdata[COMPW-1:0] = histAddr;
      default: ;
    endcase
  end
endmodule

// File: rtl/hist_datapath.sv
module hist_datapath
  import hist_pkg::*;
#(
  parameter int CNTW = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlBus_t     ctl,
  input  logic [31:0] pixData,
  input  logic [7:0]  regAddr,
  output logic [31:0] statRdata
);
  localparam int NFINE   = 1 << COMPW;
  localparam int CBITS   = COMPW - 2;
  localparam int NCOARSE = 1 << CBITS;
  localparam int SUMW    = CNTW + COMPW;

  logic [COMPW-1:0] comp [3];
  logic [COMPW-1:0] slotVal [3];
  logic [COMPW-1:0] maxV;
  logic [NFINE-1:0][CNTW-1:0] binFlat;
  logic [COMPW-1:0] minR [3];
  logic [COMPW-1:0] maxR [3];
  logic [SUMW-1:0]  sumR [3];

  always_comb begin
    comp[0] = pixData[23:16];
    comp[1] = pixData[15:8];
    comp[2] = pixData[7:0];
    maxV = comp[0];
    if (comp[1] > maxV) maxV = comp[1];
    if (comp[2] > maxV) maxV = comp[2];
    slotVal[0] = comp[0];
    slotVal[1] = ctl.maxRgb ? maxV : comp[1];
    slotVal[2] = comp[2];
  end

  for (genvar c = 0; c < 3; c++) begin : g_slot
    logic [SUMW:0] sumNext;
    assign sumNext = {1'b0, sumR[c]} + (SUMW+1)'(slotVal[c]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        minR[c] <= '1; maxR[c] <= '0; sumR[c] <= '0;
      end else if (ctl.clear) begin
        minR[c] <= '1; maxR[c] <= '0; sumR[c] <= '0;
      end else if (ctl.take) begin
        if (slotVal[c] < minR[c]) minR[c] <= slotVal[c];
        if (slotVal[c] > maxR[c]) maxR[c] <= slotVal[c];
        sumR[c] <= sumNext[SUMW] ? '1 : sumNext[SUMW-1:0];
      end
    end
  end

  for (genvar e = 0; e < NFINE; e++) begin : g_bin
    logic            hitCoarse, hit;
    logic [CNTW-1:0] cnt;
    if (e < 3 * NCOARSE) begin : g_coarse
      localparam int CH = e / NCOARSE;
      logic match;
      assign match = slotVal[CH][COMPW-1 -: CBITS] == CBITS'(e % NCOARSE);
      if (CH == 1) begin : g_mid
        assign hitCoarse = match;
      end else begin : g_side
        assign hitCoarse = match && !ctl.maxRgb;
      end
    end else begin : g_spare
      assign hitCoarse = 1'b0;
    end
    assign hit = ctl.fine ? (slotVal[1] == COMPW'(e)) : hitCoarse;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else if (ctl.clear) cnt <= '0;
      else if (ctl.take && hit && !(&cnt)) cnt <= cnt + 1'b1;
    end
    assign binFlat[e] = cnt;
  end

  logic [7:0] directIdx;
  assign directIdx = regAddr - 8'h40;

  always_comb begin
    statRdata = '0;
    if (regAddr >= 8'h40) statRdata = 32'(binFlat[directIdx]);
    else begin
      case (regAddr)
        8'h05: statRdata = 32'(binFlat[ctl.histAddr]);
        8'h08, 8'h09, 8'h0A: statRdata = {16'b0, maxR[regAddr[1:0]], minR[regAddr[1:0]]};
        8'h0C, 8'h0D, 8'h0E: statRdata = 32'(sumR[regAddr[1:0]]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hist_gen.sv
module hist_gen
  import hist_pkg::*;
#(
  parameter int COORDW = 13,
  parameter int RATIOW = 4,
  parameter int CNTW   = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sof,
  input  logic        eof,
  input  logic        pixValid,
  input  logic        pixEol,
  input  logic [31:0] pixData,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata
);
  ctlBus_t     ctlBus;
  logic [31:0] cfgRdata, statRdata;

  hist_ctrl #(.COORDW(COORDW), .RATIOW(RATIOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sof(sof), .eof(eof), .pixValid(pixValid),
    .pixEol(pixEol), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .cfgRdata(cfgRdata), .ctl(ctlBus)
  );

  hist_datapath #(.CNTW(CNTW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .pixData(pixData),
    .regAddr(regAddr), .statRdata(statRdata)
  );

  assign regRdata = cfgRdata | statRdata;
endmodule

// File: rtl/hist_gen_chk.sv
module hist_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sof,
  input logic        eof,
  input logic        pixValid,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic [31:0] regRdata,
  input logic        take,
  input logic        clear
);
  assert_valid_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    take |-> pixValid);

  assert_sof_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    sof |-> !take);

  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(eof) && !sof) |-> !take);

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h05 && $past(regAddr) == 8'h05 && !$past(regWrEn) && !$past(clear))
      |-> regRdata >= $past(regRdata));

  assert_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clear) && regAddr == 8'h05) |-> regRdata == 32'd0);
endmodule

bind hist_gen hist_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .sof(sof), .eof(eof), .pixValid(pixValid),
  .regWrEn(regWrEn), .regAddr(regAddr), .regRdata(regRdata),
  .take(ctlBus.take), .clear(ctlBus.clear)
);

// File: tb/test_hist_gen.sv
`timescale 1ns/1ps
module test_hist_gen;
  localparam int COORDW = 8;
  localparam int RATIOW = 3;
  localparam int CNTW   = 5;
  localparam int IMW    = 12;
  localparam int IMH    = 10;
  localparam int BINSAT = (1 << CNTW) - 1;
  localparam int SUMSAT = (1 << (CNTW + 8)) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sof = 1'b0, eof = 1'b0, pixValid = 1'b0, pixEol = 1'b0, regWrEn = 1'b0;
  logic [31:0] pixData = '0, regWdata = '0, regRdata;
  logic [7:0] regAddr = '0;

  hist_gen #(.COORDW(COORDW), .RATIOW(RATIOW), .CNTW(CNTW)) i_hist_gen (
    .clk(clk), .rstN(rstN), .sof(sof), .eof(eof), .pixValid(pixValid),
    .pixEol(pixEol), .pixData(pixData), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int expBin [256];
  int expMin [3], expMax [3], expSum [3];
  int cL, cT, cW, cH, cHr, cVr;
  bit cFine, cMax, cAuto;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); regWrEn = 1'b1; regAddr = 8'(a); regWdata = 32'(d);
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); regAddr = 8'(a);
    #1 v = int'(regRdata);
  endtask

  task automatic modelClear();
    for (int i = 0; i < 256; i++) expBin[i] = 0;
    for (int c = 0; c < 3; c++) begin expMin[c] = 255; expMax[c] = 0; expSum[c] = 0; end
  endtask

  function automatic int pixVal(int pat, int x, int y, int c);
    case (pat)
      0: return (c == 0) ? ((x * 21 + y * 5) & 255) :
                (c == 1) ? ((x * 7 + y * 40 + 3) & 255) : ((255 - x * 13 - y * 9) & 255);
      1: return (c == 0) ? 8'h80 : (c == 1) ? 8'h81 : 8'h7F;
      default: return (c == 0) ? ((x * y * 3) & 255) :
                      (c == 1) ? ((x + y * 16) & 255) : ((x * 29) & 255);
    endcase
  endfunction

  task automatic cfg(int l, int t, int w, int h, int hr, int vr, bit f, bit m);
    wr(1, (t << 16) | l);
    wr(2, (h << 16) | w);
    wr(3, int'(f) | (int'(m) << 1) | (hr << 8) | (vr << 16));
    cL = l; cT = t; cW = w; cH = h; cHr = hr; cVr = vr; cFine = f; cMax = m;
  endtask

  task automatic frame(int pat, bit withSof, bit counted);
    if (withSof) begin
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
      if (cAuto) modelClear();
    end
    for (int y = 0; y < IMH; y++) begin
      for (int x = 0; x < IMW; x++) begin
        int v [3];
        @(negedge clk);
        pixValid = 1'b1;
        pixEol = (x == IMW - 1);
        for (int c = 0; c < 3; c++) v[c] = pixVal(pat, x, y, c);
        pixData = {8'hA5, 8'(v[0]), 8'(v[1]), 8'(v[2])};
        if (counted && x >= cL && x < cL + cW && y >= cT && y < cT + cH &&
            ((x - cL) % (cHr + 1)) == 0 && ((y - cT) % (cVr + 1)) == 0) begin
          int mx, s [3];
          mx = v[0];
          if (v[1] > mx) mx = v[1];
          if (v[2] > mx) mx = v[2];
          s[0] = v[0]; s[1] = cMax ? mx : v[1]; s[2] = v[2];
          for (int c = 0; c < 3; c++) begin
            if (s[c] < expMin[c]) expMin[c] = s[c];
            if (s[c] > expMax[c]) expMax[c] = s[c];
            expSum[c] += s[c];
          end
          if (cFine) expBin[s[1]]++;
          else if (cMax) expBin[64 + (s[1] >> 2)]++;
          else for (int c = 0; c < 3; c++) expBin[c * 64 + (s[c] >> 2)]++;
        end
      end
    end
    @(negedge clk); pixValid = 1'b0; pixEol = 1'b0; eof = 1'b1;
    @(negedge clk); eof = 1'b0;
  endtask

  task automatic compareAll(string req);
    int v, e;
    if (cFine) begin
      for (int i = 0; i < 256; i++) begin
        wr(4, i);
        rd(5, v);
        e = (expBin[i] > BINSAT) ? BINSAT : expBin[i];
        chk(req, $sformatf("fine bin %0d", i), v, e);
      end
    end else begin
      for (int i = 0; i < 192; i++) begin
        rd(8'h40 + i, v);
        e = (expBin[i] > BINSAT) ? BINSAT : expBin[i];
        chk(req, $sformatf("bin entry %0d", i), v, e);
      end
    end
    for (int c = 0; c < 3; c++) begin
      rd(8 + c, v);
      chk("R7", $sformatf("%s extremes slot %0d", req, c), v, (expMax[c] << 8) | expMin[c]);
      rd(12 + c, v);
      e = (expSum[c] > SUMSAT) ? SUMSAT : expSum[c];
      chk("R7", $sformatf("%s sum slot %0d", req, c), v, e);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    cAuto = 0; cL = 0; cT = 0; cW = 0; cH = 0; cHr = 0; cVr = 0; cFine = 0; cMax = 0;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3, v);  chk("R1", "mode reg", v, 0);
    rd(9, v);  chk("R1", "extremes slot 1", v, 32'h00FF);
    rd(13, v); chk("R1", "sum slot 1", v, 0);
    rd(8'h40, v); chk("R1", "bin entry 0", v, 0);
    rd(5, v);  chk("R1", "indirect bin 0", v, 0);

    wr(0, 2); cAuto = 1;
    cfg(2, 1, 8, 7, 0, 0, 0, 0);   frame(0, 1, 1); compareAll("R2");
    cfg(0, 0, 12, 10, 0, 0, 0, 0); frame(0, 1, 1); compareAll("R4");
    cfg(1, 0, 11, 10, 1, 2, 0, 0); frame(0, 1, 1); compareAll("R3");
    cfg(3, 3, 9, 7, 2, 1, 0, 0);   frame(2, 1, 1); compareAll("R3");
    cfg(0, 0, 12, 10, 0, 0, 0, 1); frame(0, 1, 1); compareAll("R5");
    cfg(3, 2, 7, 6, 0, 0, 1, 0);   frame(2, 1, 1); compareAll("R6");
    cfg(0, 0, 12, 10, 0, 1, 1, 1); frame(0, 1, 1); compareAll("R6");
    cfg(0, 0, 12, 10, 0, 0, 0, 0); frame(1, 1, 1); compareAll("R8");

    // R11: a second frame streamed with no start pulse changes nothing
    frame(0, 1, 1); frame(2, 0, 0); compareAll("R11");

    // R10: accumulate when the start-of-frame clear is not armed
    wr(0, 0); cAuto = 0;
    frame(0, 1, 1); frame(2, 1, 1); compareAll("R10");

    // R9: clear bit
    wr(0, 1); modelClear(); compareAll("R9");

    // R10: armed again, start of frame discards the earlier result
    wr(0, 2); cAuto = 1;
    frame(0, 1, 1); frame(2, 1, 1); compareAll("R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule